// File: doc/BRIEF.md
# Frame Serializer with Bypass Select

This block sits at the end of a receive processing chain. Each clock it may be offered one beat of four parallel 32-bit complex samples (16-bit real, 16-bit imaginary packed in one word) from two sources. One source is a channelized path that carries frequency bins. The other is a raw bypass path used for debug and comparison. A mode input picks which source feeds the output. The chosen beats go into a small FIFO that is written four words at a time and read one word at a time. The FIFO drains as a single AXI4-Stream master with one 32-bit word per beat.

Output words are grouped into frames of 512 samples, and TLAST marks the last word of every frame. A change of the mode input only takes hold at the start of an input frame, so a frame never mixes the two sources. The FIFO absorbs the 4:1 rate difference and any backpressure from downstream. A beat that finds too little room in the FIFO is dropped and sets a sticky overflow flag.

Top module: `frame_serializer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `m_tvalid`, `m_tlast` and `overflow` are 0, and reset clears any earlier overflow.
- R2: The four 32-bit words of an accepted beat appear on `m_tdata` unchanged, in lane order 0, 1, 2, 3. Lane i occupies bits [32*i+31 : 32*i] of the input bus.
- R3: With the default FIFO depth of 16 words, a beat on the selected source is accepted only when at least 4 words are free. Otherwise it is dropped and never reaches the output, and `overflow` goes to 1 and stays at 1 until reset.
- R4: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R5: `m_tlast` is 1 exactly on the 512th, 1024th, ... word since reset, counting only completed handshakes (`m_tvalid` and `m_tready` both 1).
- R6: `mode_sel` = 0 selects the channelized source and `mode_sel` = 1 selects the bypass source. The value is taken when the first beat of an input frame is accepted (every 128 accepted beats, starting after reset). A change in the middle of a frame has no effect until the next frame begins.
- R7: The valid and data inputs of the source that is not selected have no effect on the output stream. In bypass mode the raw words pass through unmodified with the same framing.
- R8: `m_tvalid` goes high on the clock edge that accepts a beat into an empty FIFO, and then shows lane 0 of that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Source request: 0 channelized, 1 bypass |
| chan_valid | input | 1 | Channelized beat present |
| chan_data | input | 128 | Channelized four-lane beat, lane 0 in the low bits |
| byp_valid | input | 1 | Bypass beat present |
| byp_data | input | 128 | Bypass four-lane beat, lane 0 in the low bits |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 32 | Stream word (packed complex sample) |
| m_tlast | output | 1 | Last word of a 512-sample frame |
| overflow | output | 1 | Sticky flag: a beat was dropped |

## Verification
A beat accepted on one rising edge shows its lane 0 word on the outputs right after that edge. Each later word appears one edge after the handshake that consumed the previous one. So the bench drives inputs on falling edges and checks each word on the falling edge that follows the edge that produced it. The overflow flag is checked on the falling edge after the dropped beat's edge. The reset values are checked on the falling edge after the first reset edge. The mode change is checked across a whole frame of 128 beats, because its effect is only due at the first beat of the next frame.

// File: rtl/fser_pkg.sv
package fser_pkg;

    localparam int unsigned LANES_DEF      = 4;
    localparam int unsigned WORD_W_DEF     = 32;
    localparam int unsigned FRAME_LEN_DEF  = 512;
    localparam int unsigned FIFO_DEPTH_DEF = 16;

    // Source selection encoding
    typedef enum logic {
        SRC_CHAN   = 1'b0,
        SRC_BYPASS = 1'b1
    } src_e;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/fser_lane_mux.sv
module fser_lane_mux
    import fser_pkg::*;
#(
    parameter int unsigned BUS_W = LANES_DEF * WORD_W_DEF
) (
    input  src_e               sel,
    input  logic               chan_valid,
    input  logic [BUS_W-1:0]   chan_data,
    input  logic               byp_valid,
    input  logic [BUS_W-1:0]   byp_data,
    output logic               out_valid,
    output logic [BUS_W-1:0]   out_data
);

    always_comb begin
        if (sel == SRC_BYPASS) begin
            out_valid = byp_valid;
            out_data  = byp_data;
        end else begin
            out_valid = chan_valid;
            out_data  = chan_data;
        end
    end

endmodule

// File: rtl/fser_frame_ctr.sv
module fser_frame_ctr #(
    parameter int unsigned LEN = 128,
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (adv) begin
            if (count == CW'(LEN - 1)) count <= '0;
            else                       count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/fser_fifo.sv
module fser_fifo #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned LANES  = 4,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [LANES*WORD_W-1:0] wr_data,
    input  logic                    rd_en,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    empty,
    output logic                    room
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     fill;

    // Wide write: all lanes land in consecutive slots, lane 0 first
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < int'(LANES); l++) begin
                mem[wr_ptr + AW'(l)] <= wr_data[l*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + AW'(LANES);
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + (wr_en ? CW'(LANES) : '0) - (rd_en ? CW'(1) : '0);
        end
    end

    assign rd_data = mem[rd_ptr];
    assign empty   = (fill == '0);
    assign room    = (fill <= CW'(DEPTH - LANES));

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import fser_pkg::*;
#(
    parameter int unsigned LANES      = LANES_DEF,
    parameter int unsigned WORD_W     = WORD_W_DEF,
    parameter int unsigned FRAME_LEN  = FRAME_LEN_DEF,
    parameter int unsigned FIFO_DEPTH = FIFO_DEPTH_DEF,
    localparam int unsigned BUS_W     = LANES * WORD_W,
    localparam int unsigned BEATS     = FRAME_LEN / LANES,
    localparam int unsigned IN_CW     = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int unsigned OUT_CW    = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              chan_valid,
    input  logic [BUS_W-1:0]  chan_data,
    input  logic              byp_valid,
    input  logic [BUS_W-1:0]  byp_data,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [WORD_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              overflow
);

    generate
        if (!is_pow2(FIFO_DEPTH) || (FIFO_DEPTH % LANES) != 0 || (FRAME_LEN % LANES) != 0) begin : g_bad_cfg
            $error("frame_serializer: FIFO depth must be a power of two; depth and frame length must be multiples of the lane count");
        end
    endgenerate

    src_e              mode_q;
    src_e              mode_eff;
    logic              sel_valid;
    logic [BUS_W-1:0]  sel_data;
    logic              accept;
    logic              fifo_empty;
    logic              fifo_room;
    logic              handshake;
    logic              ovf_q;
    logic [IN_CW-1:0]  in_cnt;
    logic [OUT_CW-1:0] out_cnt;

    // Source choice is re-evaluated only while the input frame counter is at its start
    assign mode_eff = (in_cnt == '0) ? src_e'(mode_sel) : mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= SRC_CHAN;
        else     mode_q <= mode_eff;
    end

    fser_lane_mux #(
        .BUS_W (BUS_W)
    ) u_mux (
        .sel        (mode_eff),
        .chan_valid (chan_valid),
        .chan_data  (chan_data),
        .byp_valid  (byp_valid),
        .byp_data   (byp_data),
        .out_valid  (sel_valid),
        .out_data   (sel_data)
    );

    assign accept    = sel_valid && fifo_room;
    assign handshake = m_tvalid && m_tready;

    fser_fifo #(
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_data (sel_data),
        .rd_en   (handshake),
        .rd_data (m_tdata),
        .empty   (fifo_empty),
        .room    (fifo_room)
    );

    // Input-side frame position, in beats
    fser_frame_ctr #(
        .LEN (BEATS)
    ) u_in_ctr (
        .clk   (clk),
        .rst   (rst),
        .adv   (accept),
        .count (in_cnt)
    );

    // Output-side frame position, in words
    fser_frame_ctr #(
        .LEN (FRAME_LEN)
    ) u_out_ctr (
        .clk   (clk),
        .rst   (rst),
        .adv   (handshake),
        .count (out_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst)                         ovf_q <= 1'b0;
        else if (sel_valid && !fifo_room) ovf_q <= 1'b1;
    end

    assign m_tvalid = !fifo_empty;
    assign m_tlast  = m_tvalid && (out_cnt == OUT_CW'(FRAME_LEN - 1));
    assign overflow = ovf_q;

endmodule

// File: rtl/fser_checker.sv
module fser_checker #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned FRAME_LEN = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [WORD_W-1:0] m_tdata,
    input logic              m_tlast,
    input logic              overflow
);

    int unsigned hs_cnt;

    always_ff @(posedge clk) begin
        if (rst) hs_cnt <= 0;
        else if (m_tvalid && m_tready) hs_cnt <= (hs_cnt == FRAME_LEN - 1) ? 0 : hs_cnt + 1;
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!m_tvalid && !m_tlast && !overflow));

    // R3
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R4
    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R5
    a_r5_last_position: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tlast == (hs_cnt == FRAME_LEN - 1)));

    // R5
    a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
        m_tlast |-> m_tvalid);

endmodule

bind frame_serializer fser_checker #(
    .WORD_W    (WORD_W),
    .FRAME_LEN (FRAME_LEN)
) u_fser_chk (
    .clk      (clk),
    .rst      (rst),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .overflow (overflow)
);

// File: tb/test_frame_serializer.sv
module test_frame_serializer;

    localparam int LN = 4;
    localparam int WW = 32;
    localparam int FL = 512;
    localparam int BW = LN * WW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_sel = 1'b0;
    logic          chan_valid = 1'b0;
    logic          byp_valid = 1'b0;
    logic [BW-1:0] chan_data = '0;
    logic [BW-1:0] byp_data = '0;
    logic          m_tready = 1'b1;
    logic          m_tvalid;
    logic [WW-1:0] m_tdata;
    logic          m_tlast;
    logic          overflow;

    int errors = 0;
    int checks = 0;
    int wcnt   = 0;
    bit done   = 1'b0;

    // Stimulus table: lane 0 in the low 32 bits
    localparam logic [BW-1:0] TBL [8] = '{
        128'h7FFF0000_80000000_FFFFFFFF_00000000,
        128'h00000001_00010000_7FFF7FFF_80008000,
        128'h12345678_9ABCDEF0_0F0F0F0F_F0F0F0F0,
        128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF,
        128'h80007FFF_7FFF8000_00008000_80000000,
        128'hAAAAAAAA_55555555_AAAA5555_5555AAAA,
        128'h00000003_00000002_00000001_00000000,
        128'hFFFF0001_0001FFFF_C0004000_4000C000
    };

    frame_serializer i_frame_serializer (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .chan_valid (chan_valid),
        .chan_data  (chan_data),
        .byp_valid  (byp_valid),
        .byp_data   (byp_data),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tdata    (m_tdata),
        .m_tlast    (m_tlast),
        .overflow   (overflow)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] gen(input int b, input bit byp);
        logic [BW-1:0] v;
        for (int l = 0; l < LN; l++) begin
            v[l*WW +: WW] = {(byp ? 8'hB7 : 8'hC3), 4'(l), 4'h0, 16'(b)};
        end
        return v;
    endfunction

    task automatic send(input logic [BW-1:0] cd, input logic [BW-1:0] bd);
        @(negedge clk);
        chan_data  = cd;
        byp_data   = bd;
        chan_valid = 1'b1;
        byp_valid  = 1'b1;
        @(negedge clk);
        chan_valid = 1'b0;
        byp_valid  = 1'b0;
    endtask

    // Checks four consecutive words with ready held high
    task automatic drain4(input logic [BW-1:0] exp, input string req);
        for (int i = 0; i < LN; i++) begin
            logic [WW-1:0] e;
            logic          el;
            e  = exp[i*WW +: WW];
            el = ((wcnt % FL) == FL - 1);
            check(m_tvalid && m_tdata == e && m_tlast == el, req,
                  {6'd0, m_tvalid, m_tlast, m_tdata}, {6'd0, 1'b1, el, e});
            wcnt++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check({m_tvalid, m_tlast, overflow} == 3'b000, "R1 reset outputs",
              {37'd0, m_tvalid, m_tlast, overflow}, 40'd0);
        rst = 1'b0;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R8 idle after reset", {39'd0, m_tvalid}, 40'd0);

        // Table walk, channelized mode, bypass lanes carry other data (R2, R7, R8)
        for (int r = 0; r < 8; r++) begin
            send(TBL[r], ~TBL[r]);
            drain4(TBL[r], "R2 R7 R8 lane order channel");
        end

        // Rest of frame 0; request bypass in the middle (R6, R5)
        for (int b = 8; b < FL / LN; b++) begin
            if (b == 64) mode_sel = 1'b1;
            send(gen(b, 1'b0), gen(b, 1'b1));
            drain4(gen(b, 1'b0), "R6 R5 mid-frame change ignored");
        end

        // Frame 1 is bypass; a request back to channel mid-frame is ignored (R6, R7)
        for (int b = 0; b < 10; b++) begin
            if (b == 3) mode_sel = 1'b0;
            send(gen(b + 700, 1'b0), gen(b, 1'b1));
            drain4(gen(b, 1'b1), "R6 R7 bypass frame");
        end

        // R3/R4: stall output, offer five beats back to back
        m_tready = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chan_data  = gen(900 + k, 1'b0);
            byp_data   = gen(100 + k, 1'b1);
            chan_valid = 1'b1;
            byp_valid  = 1'b1;
        end
        @(negedge clk);
        chan_valid = 1'b0;
        byp_valid  = 1'b0;
        check(overflow == 1'b1, "R3 overflow raised", {39'd0, overflow}, 40'd1);
        check(m_tvalid && m_tdata == gen(100, 1'b1)[WW-1:0], "R4 stall word",
              {7'd0, m_tvalid, m_tdata}, {7'd0, 1'b1, gen(100, 1'b1)[WW-1:0]});
        repeat (3) @(negedge clk);
        check(m_tvalid && m_tdata == gen(100, 1'b1)[WW-1:0] && !m_tlast, "R4 held during stall",
              {6'd0, m_tvalid, m_tlast, m_tdata}, {6'd0, 2'b10, gen(100, 1'b1)[WW-1:0]});
        m_tready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            drain4(gen(100 + k, 1'b1), "R3 accepted beats drained");
        end
        check(m_tvalid == 1'b0, "R3 dropped beat absent", {39'd0, m_tvalid}, 40'd0);
        check(overflow == 1'b1, "R3 overflow sticky", {39'd0, overflow}, 40'd1);

        // R1: reset clears overflow; new frame starts in channel mode (R6)
        rst = 1'b1;
        @(negedge clk);
        check({m_tvalid, m_tlast, overflow} == 3'b000, "R1 reset clears",
              {37'd0, m_tvalid, m_tlast, overflow}, 40'd0);
        rst  = 1'b0;
        wcnt = 0;
        send(gen(5, 1'b0), gen(5, 1'b1));
        drain4(gen(5, 1'b0), "R1 R6 channel after reset");

        finish_run();
    end

endmodule